// File: doc/BRIEF.md
# Store Buffer Data Array with Load Forwarding

This block holds the data half of a store buffer shared by four hardware threads, each owning eight entries. A store writes its 64-bit data into the entry chosen by its thread id and entry pointer, in the same cycle that the address side records the store's address and byte mask. The write also marks the entry valid. A separate release strobe clears an entry's valid bit when the store has drained to memory.

A load that has been compared against the address side arrives with its thread id, an encoded hit pointer and two match vectors: one bit per entry of that thread for a fully covered match, and one for a partial overlap. The block masks both vectors with its own valid bits. It then classifies the load, one cycle later, as forwarded (with the stored data), replayed (it must wait behind an older store), or missed (it goes to memory). The result is a flow out of the block with no back-pressure. `res_valid` is high for exactly one cycle per load, and the consumer must take it in that cycle. The block has no ready input and buffers nothing.

The array has a single port. A store write and a forwarding read in the same cycle form a collision. The write is kept, the load is replayed, and `rw_conflict` flags the event.

Top module: `sbuf_fwd_array`

## Requirements
- R1: The array holds 32 entries of 64 bits, indexed by {tid[1:0], ptr[2:0]}. A store write (`st_wr_en`) stores `st_data` at {st_tid, st_ptr} and sets that entry's valid bit.
- R2: A release (`rel_en`) clears the valid bit at {rel_tid, rel_ptr}. A store write and a release to the same entry in one cycle leave the entry valid. A synchronous reset (`rst` high) clears all valid bits.
- R3: Bit i of `ld_full_raw` and of `ld_part_raw` refers to entry {ld_tid, i}. Each bit counts as a hit only if that entry is valid. Validity is taken as it stood before the current cycle's writes and releases.
- R4: A load with exactly one qualified hit, where that hit is in the full vector and not in the partial vector, and with no store write in the same cycle, is forwarded. One cycle later, `res_valid` and `fwd_valid` are 1 and `fwd_data` equals the entry at {ld_tid, ld_hit_ptr}.
- R5: A load with any qualified partial hit, or with two or more qualified hits, gives `res_valid` and `ld_replay` one cycle later. It is never forwarded, whatever the hit pointer holds.
- R6: A load with no qualified hit gives `res_valid` and `ld_miss` one cycle later.
- R7: The array is read only for a load with at least one qualified full hit. If a store write occurs in the same cycle, `rw_conflict` is 1 in that cycle, the write completes, and the load is replayed one cycle later.
- R8: Each load produces exactly one of `fwd_valid`, `ld_replay` and `ld_miss`, together with `res_valid`, exactly one cycle after `ld_req`. With no load, all four are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_wr_en | input | 1 | Store data write strobe |
| st_tid | input | 2 | Thread of the store |
| st_ptr | input | 3 | Entry pointer of the store |
| st_data | input | 64 | Store data |
| rel_en | input | 1 | Entry release strobe |
| rel_tid | input | 2 | Thread of the released entry |
| rel_ptr | input | 3 | Pointer of the released entry |
| ld_req | input | 1 | Load lookup present this cycle |
| ld_tid | input | 2 | Thread of the load |
| ld_hit_ptr | input | 3 | Encoded hit pointer from the address side |
| ld_full_raw | input | 8 | Full-coverage match per entry of the load's thread |
| ld_part_raw | input | 8 | Partial-overlap match per entry of the load's thread |
| res_valid | output | 1 | A load result is present |
| fwd_valid | output | 1 | Result: data forwarded |
| fwd_data | output | 64 | Forwarded data |
| ld_replay | output | 1 | Result: load must wait behind a store |
| ld_miss | output | 1 | Result: no valid store matches |
| rw_conflict | output | 1 | Store write and forwarding read requested together |

## Verification
The two functions that can fall in the same cycle are the store write and the forwarding read of a load that has a valid full hit. They also share the valid bits that a same-cycle store or release may be changing. The bench provokes the collision by driving a store and a single-full-hit load together. It then expects `rw_conflict` in that cycle, a replay in the next, and the store's data forwarded on a later load. It also drives a release or a store in the same cycle as a load that hits the touched entry, and judges the load against the validity that held before that cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned THREADS  = 4;
  localparam int unsigned PER_THR  = 8;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned TID_W    = $clog2(THREADS);
  localparam int unsigned PTR_W    = $clog2(PER_THR);
  localparam int unsigned IDX_W    = TID_W + PTR_W;
  localparam int unsigned NUM_ENT  = THREADS * PER_THR;

  typedef enum logic [1:0] {
    OUT_MISS   = 2'd0,
    OUT_FWD    = 2'd1,
    OUT_REPLAY = 2'd2
  } ld_outcome_e;

  function automatic int unsigned popcnt(input logic [PER_THR-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < PER_THR; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/sbuf_valid_bits.sv
module sbuf_valid_bits
  import sbuf_pkg::*;
#(
  parameter int unsigned N = NUM_ENT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     vld
);
  for (genvar e = 0; e < N; e++) begin : g_ent
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(e));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (rst)          vld[e] <= 1'b0;
      else if (hit_set) vld[e] <= 1'b1;
      else if (hit_clr) vld[e] <= 1'b0;
    end
  end
endmodule

// File: rtl/sbuf_data_ram.sv
module sbuf_data_ram
  import sbuf_pkg::*;
#(
  parameter int unsigned N = NUM_ENT,
  parameter int unsigned W = DATA_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [N];

  // Single port: a write takes the port, a colliding read is dropped.
  always_ff @(posedge clk) begin
    if (we)      mem[widx] <= wdata;
    else if (re) rdata     <= mem[ridx];
  end
endmodule

// File: rtl/sbuf_ld_decide.sv
module sbuf_ld_decide
  import sbuf_pkg::*;
(
  input  logic               ld_req,
  input  logic [TID_W-1:0]   ld_tid,
  input  logic [PER_THR-1:0] full_raw,
  input  logic [PER_THR-1:0] part_raw,
  input  logic [NUM_ENT-1:0] vld,
  output logic               rd_req,
  output ld_outcome_e        outcome
);
  logic [PER_THR-1:0] thr_vld;
  logic [PER_THR-1:0] q_full;
  logic [PER_THR-1:0] q_part;
  int unsigned        nhit;

  assign thr_vld = vld[ld_tid*PER_THR +: PER_THR];
  assign q_full  = full_raw & thr_vld;
  assign q_part  = part_raw & thr_vld;
  assign nhit    = popcnt(q_full | q_part);
  assign rd_req  = ld_req && (q_full != '0);

  always_comb begin
    if (nhit == 0)                       outcome = OUT_MISS;
    else if (nhit == 1 && q_part == '0)  outcome = OUT_FWD;
    else                                 outcome = OUT_REPLAY;
  end
endmodule

// File: rtl/sbuf_fwd_array.sv
module sbuf_fwd_array
  import sbuf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                st_wr_en,
  input  logic [TID_W-1:0]    st_tid,
  input  logic [PTR_W-1:0]    st_ptr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic                rel_en,
  input  logic [TID_W-1:0]    rel_tid,
  input  logic [PTR_W-1:0]    rel_ptr,
  input  logic                ld_req,
  input  logic [TID_W-1:0]    ld_tid,
  input  logic [PTR_W-1:0]    ld_hit_ptr,
  input  logic [PER_THR-1:0]  ld_full_raw,
  input  logic [PER_THR-1:0]  ld_part_raw,
  output logic                res_valid,
  output logic                fwd_valid,
  output logic [DATA_W-1:0]   fwd_data,
  output logic                ld_replay,
  output logic                ld_miss,
  output logic                rw_conflict
);
  logic [NUM_ENT-1:0] vld;
  logic               rd_req;
  ld_outcome_e        outcome;
  ld_outcome_e        final_out;

  sbuf_valid_bits u_vld (
    .clk     (clk),
    .rst     (rst),
    .set_en  (st_wr_en),
    .set_idx ({st_tid, st_ptr}),
    .clr_en  (rel_en),
    .clr_idx ({rel_tid, rel_ptr}),
    .vld     (vld)
  );

  sbuf_ld_decide u_dec (
    .ld_req   (ld_req),
    .ld_tid   (ld_tid),
    .full_raw (ld_full_raw),
    .part_raw (ld_part_raw),
    .vld      (vld),
    .rd_req   (rd_req),
    .outcome  (outcome)
  );

  sbuf_data_ram u_ram (
    .clk   (clk),
    .we    (st_wr_en),
    .widx  ({st_tid, st_ptr}),
    .wdata (st_data),
    .re    (rd_req),
    .ridx  ({ld_tid, ld_hit_ptr}),
    .rdata (fwd_data)
  );

  assign rw_conflict = rd_req && st_wr_en;

  always_comb begin
    final_out = outcome;
    if (rw_conflict) final_out = OUT_REPLAY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      fwd_valid <= 1'b0;
      ld_replay <= 1'b0;
      ld_miss   <= 1'b0;
    end else begin
      res_valid <= ld_req;
      fwd_valid <= ld_req && (final_out == OUT_FWD);
      ld_replay <= ld_req && (final_out == OUT_REPLAY);
      ld_miss   <= ld_req && (final_out == OUT_MISS);
    end
  end
endmodule

// File: rtl/sbuf_fwd_chk.sv
module sbuf_fwd_chk
  import sbuf_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ld_req,
  input logic [PER_THR-1:0] ld_full_raw,
  input logic [PER_THR-1:0] ld_part_raw,
  input logic               st_wr_en,
  input logic               rw_conflict,
  input logic               res_valid,
  input logic               fwd_valid,
  input logic               ld_replay,
  input logic               ld_miss
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({fwd_valid, ld_replay, ld_miss}) == 1)); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!fwd_valid && !ld_replay && !ld_miss)); // R8
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> res_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !ld_req |=> !res_valid); // R8
  AST_NO_RAW_MISS: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_full_raw == '0 && ld_part_raw == '0) |=> ld_miss); // R6
  AST_CONFLICT_REPLAY: assert property (@(posedge clk) disable iff (rst)
    rw_conflict |=> ld_replay); // R7
  AST_CONFLICT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rw_conflict |-> (st_wr_en && ld_req && ld_full_raw != '0)); // R7
endmodule

bind sbuf_fwd_array sbuf_fwd_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ld_req      (ld_req),
  .ld_full_raw (ld_full_raw),
  .ld_part_raw (ld_part_raw),
  .st_wr_en    (st_wr_en),
  .rw_conflict (rw_conflict),
  .res_valid   (res_valid),
  .fwd_valid   (fwd_valid),
  .ld_replay   (ld_replay),
  .ld_miss     (ld_miss)
);

// File: tb/tb_sbuf_fwd_array.sv
module tb_sbuf_fwd_array;
  logic        clk = 1'b0;
  logic        rst;
  logic        st_wr_en = 0;
  logic [1:0]  st_tid = 0;
  logic [2:0]  st_ptr = 0;
  logic [63:0] st_data = 0;
  logic        rel_en = 0;
  logic [1:0]  rel_tid = 0;
  logic [2:0]  rel_ptr = 0;
  logic        ld_req = 0;
  logic [1:0]  ld_tid = 0;
  logic [2:0]  ld_hit_ptr = 0;
  logic [7:0]  ld_full_raw = 0;
  logic [7:0]  ld_part_raw = 0;
  logic        res_valid, fwd_valid, ld_replay, ld_miss, rw_conflict;
  logic [63:0] fwd_data;

  int errors = 0;
  int checks = 0;

  // Scoreboard item: {fwd, replay, miss, data}
  logic [66:0] sb_q [$];
  string       sb_tag [$];

  logic [63:0] ref_mem [32];
  logic [31:0] ref_vld;

  always #2 clk = ~clk;

  sbuf_fwd_array dut (.*);

  task automatic chk(input string req, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one cycle of stimulus starting at a falling edge.
  task automatic cyc(input string tag,
                     input logic s_en, input logic [1:0] s_t, input logic [2:0] s_p,
                     input logic [63:0] s_d,
                     input logic r_en, input logic [1:0] r_t, input logic [2:0] r_p,
                     input logic l_en, input logic [1:0] l_t, input logic [2:0] l_p,
                     input logic [7:0] l_f, input logic [7:0] l_pr);
    logic [7:0] qf, qp;
    int nh;
    logic e_conf;
    logic [66:0] item;
    st_wr_en = s_en; st_tid = s_t; st_ptr = s_p; st_data = s_d;
    rel_en = r_en; rel_tid = r_t; rel_ptr = r_p;
    ld_req = l_en; ld_tid = l_t; ld_hit_ptr = l_p; ld_full_raw = l_f; ld_part_raw = l_pr;
    qf = l_f & ref_vld[l_t*8 +: 8];
    qp = l_pr & ref_vld[l_t*8 +: 8];
    nh = $countones(qf | qp);
    e_conf = l_en && (qf != 0) && s_en;
    if (l_en) begin
      if (nh == 0)                          item = {3'b001, 64'd0};
      else if (nh == 1 && qp == 0 && !s_en) item = {3'b100, ref_mem[{l_t, l_p}]};
      else                                  item = {3'b010, 64'd0};
      sb_q.push_back(item);
      sb_tag.push_back(tag);
    end
    #1;
    chk({tag, " R7 conflict"}, {66'd0, rw_conflict}, {66'd0, e_conf});
    if (r_en) ref_vld[{r_t, r_p}] = 1'b0;
    if (s_en) begin
      ref_vld[{s_t, s_p}] = 1'b1;
      ref_mem[{s_t, s_p}] = s_d;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cyc("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic store(input logic [1:0] t, input logic [2:0] p, input logic [63:0] d);
    cyc("R1 store", 1, t, p, d, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(input string tag, input logic [1:0] t, input logic [2:0] p,
                      input logic [7:0] f, input logic [7:0] pr);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 1, t, p, f, pr);
  endtask

  // Monitor: compares every produced result with the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        if (sb_q.size() == 0) begin
          chk("R8 unexpected result", {fwd_valid, ld_replay, ld_miss, 64'd0}, 67'd0);
        end else begin
          logic [66:0] e;
          string t;
          e = sb_q.pop_front();
          t = sb_tag.pop_front();
          chk(t, {fwd_valid, ld_replay, ld_miss, (e[66] ? fwd_data : 64'd0)}, e);
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ref_vld = '0;
    for (int i = 0; i < 32; i++) ref_mem[i] = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", {fwd_valid, ld_replay, ld_miss, 63'd0, res_valid}, 67'd0);
    rst = 1'b0;
    // R2 reset leaves every entry invalid: loads naming entries miss (R6)
    load("R2 R6 miss after reset", 2'd0, 3'd3, 8'h08, 8'h00);
    load("R6 no raw", 2'd1, 3'd0, 8'h00, 8'h00);
    idle();
    chk("R8 idle quiet", {fwd_valid, ld_replay, ld_miss, 63'd0, res_valid}, 67'd0);
    // R1 R4 single full hit forwards
    store(2'd0, 3'd3, 64'hA5A5_0000_1111_2222);
    load("R4 forward t0p3", 2'd0, 3'd3, 8'h08, 8'h00);
    // R3 thread qualification: same bit, other thread, invalid
    load("R3 other thread miss", 2'd1, 3'd3, 8'h08, 8'h00);
    // R5 partial on valid entry
    load("R5 partial replay", 2'd0, 3'd3, 8'h00, 8'h08);
    load("R5 full+partial same entry", 2'd0, 3'd3, 8'h08, 8'h08);
    // R5 multiple full hits with garbage pointer
    store(2'd0, 3'd5, 64'h5555_6666_7777_8888);
    load("R5 multi hit replay", 2'd0, 3'd7, 8'h28, 8'h00);
    // R3 partial on invalid entry is ignored
    load("R3 invalid partial ignored", 2'd0, 3'd5, 8'h20, 8'h40);
    // R2 release then miss
    cyc("R2 release", 0, 0, 0, 0, 1, 2'd0, 3'd3, 0, 0, 0, 0, 0);
    load("R2 released misses", 2'd0, 3'd3, 8'h08, 8'h00);
    // R3 release in same cycle as load: old validity still forwards
    cyc("R3 load with same-cycle release", 0, 0, 0, 0, 1, 2'd0, 3'd5, 1, 2'd0, 3'd5, 8'h20, 8'h00);
    load("R2 after release", 2'd0, 3'd5, 8'h20, 8'h00);
    // R2 store and release on same entry: stays valid
    cyc("R2 store+release", 1, 2'd2, 3'd1, 64'hDEAD_BEEF_0000_0001, 1, 2'd2, 3'd1, 0, 0, 0, 0, 0);
    load("R2 write wins", 2'd2, 3'd1, 8'h02, 8'h00);
    // R7 collision: store + single full-hit load together
    cyc("R7 collision replay", 1, 2'd3, 3'd6, 64'h0123_4567_89AB_CDEF,
        0, 0, 0, 1, 2'd2, 3'd1, 8'h02, 8'h00);
    load("R7 store kept", 2'd3, 3'd6, 8'h40, 8'h00);
    load("R7 other entry intact", 2'd2, 3'd1, 8'h02, 8'h00);
    // R3 store in same cycle as load of that entry: old validity, miss
    cyc("R3 load with same-cycle store", 1, 2'd1, 3'd4, 64'h1, 0, 0, 0, 1, 2'd1, 3'd4, 8'h00, 8'h10);
    // R1 R4 sweep all entries
    for (int i = 0; i < 32; i++)
      store(i[4:3], i[2:0], {32'hC0DE_0000 + 32'(i), ~32'(i) * 32'h9E37_79B9});
    for (int i = 0; i < 32; i++)
      load("R1 R4 sweep forward", i[4:3], i[2:0], 8'(1 << i[2:0]), 8'h00);
    // back-to-back loads of mixed kinds
    load("R5 back-to-back partial", 2'd3, 3'd0, 8'h01, 8'h02);
    load("R6 back-to-back miss", 2'd3, 3'd0, 8'h00, 8'h00);
    idle();
    idle();
    chk("R8 all results seen", {35'd0, 32'(sb_q.size())}, 67'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule